// File: doc/BRIEF.md
# TDMA slot sequencing controller

This block is the timing engine inside a central fabric manager. It leads a set of end hosts through rounds, and each round is a run of equal, fixed-length transmit slots. The controller counts every slot on its own clock. It reads the entry for each slot from an external schedule memory. The entry has a mask of the hosts that may send in that slot and, for each host, the single traffic class that host is allowed to release. Within one slot, no two senders share a link.

Each slot opens with one broadcast pause-all command, which mutes every host. The first slot of a round therefore mutes all hosts before any transmission window opens. After a programmable guard interval, the controller walks the host positions one per cycle and sends an unpause command to each scheduled host. An unpause command carries the host number and its permitted class. Hosts are grouped by switch. All hosts of one group are visited before the next group. The starting group and the starting host inside each group both advance by one every round.

Commands leave on a valid/ready request port toward a frame builder. Slot length, guard length and slots per round are given in clock cycles, for example 15000 and 750 cycles for 300 µs slots with 15 µs guards at 50 MHz. The controller takes these values only when a round begins. If back-pressure keeps the unpause walk from finishing inside the slot, the controller flags an overrun and still opens the next slot on time.

Top module: `tdma_slot_sequencer`

## Requirements
- R1: During reset and afterwards while `run` has never been high, `cmd_valid` and `overrun` are 0.
- R2: Every slot starts with exactly one pause-all command (`cmd_pause`=1, `cmd_host`=0, `cmd_class`=0), including the first slot of a round. With an accepting downstream, successive pause commands are exactly slot-length cycles apart.
- R3: The walk visits one host position per cycle. It starts in the slot cycle whose index equals the guard length, where the pause sits in slot cycle 0. The unpause for position p is therefore offered in slot cycle guard+p.
- R4: An unpause command has `cmd_pause`=0 and carries the class `sched_class[h*CLASS_W +: CLASS_W]` that the schedule entry gives for host h=`cmd_host`.
- R5: A host whose bit in `sched_mask` is 0 receives no unpause in that slot. Its walk position passes in one cycle with no command.
- R6: Host number = group*HPG + index, where HPG = 2**HIG_W. At position p in round r (rounds counted from reset), group = (p div HPG + r) mod groups and index = (p mod HPG + r) mod HPG.
- R7: Slot length, guard length and slot count are sampled only when a round starts. A change in the middle of a round takes effect at the next round.
- R8: When `run` is low at the end of a round, the controller finishes that round and then issues no further commands.
- R9: A command that has not been accepted stays valid and unchanged until `cmd_ready`, unless the slot ends first. If the walk has not finished by the last cycle of a slot, `overrun` pulses for one cycle as the next slot's pause is offered, and that pause still arrives on time.
- R10: `sched_slot` shows the index of the current slot, counting from 0 up to slot count minus 1 within each round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start rounds; sampled at each round boundary |
| cfg_slot_len | input | CNT_W | Slot length in cycles |
| cfg_guard_len | input | CNT_W | Guard length in cycles |
| cfg_num_slots | input | SLOT_W | Slots per round |
| sched_slot | output | SLOT_W | Schedule memory slot index |
| sched_mask | input | 2**(GRP_W+HIG_W) | Hosts allowed to send in the slot |
| sched_class | input | 2**(GRP_W+HIG_W)*CLASS_W | Per-host permitted class |
| cmd_valid | output | 1 | Command request |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_pause | output | 1 | 1 = pause-all broadcast, 0 = unpause |
| cmd_host | output | GRP_W+HIG_W | Target host of an unpause |
| cmd_class | output | CLASS_W | Class released by an unpause |
| overrun | output | 1 | One-cycle pulse: the last slot's walk did not finish |

## Verification
The assertions assume the following about the inputs:
- The schedule memory answers combinationally on `sched_slot`.
- Its mask and class outputs stay constant for the whole slot.
- The slot length is at least 2 and covers the guard plus one cycle per host.

The bench's schedule is a pure function of the slot index, so it satisfies the first two assumptions. Every configuration the bench programs keeps the slot length well above the guard plus the host count. The bench derives ready from `cmd_pause`, so the pause is always taken at once while unpauses can be refused.

// File: rtl/tdma_slot_sequencer.sv
module tdma_slot_sequencer #(
  parameter int GRP_W   = 1,
  parameter int HIG_W   = 1,
  parameter int CLASS_W = 3,
  parameter int SLOT_W  = 4,
  parameter int CNT_W   = 16,
  localparam int HOST_W = GRP_W + HIG_W,
  localparam int NHOSTS = 1 << HOST_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [CNT_W-1:0]          cfg_slot_len,
  input  logic [CNT_W-1:0]          cfg_guard_len,
  input  logic [SLOT_W-1:0]         cfg_num_slots,
  output logic [SLOT_W-1:0]         sched_slot,
  input  logic [NHOSTS-1:0]         sched_mask,
  input  logic [NHOSTS*CLASS_W-1:0] sched_class,
  output logic                      cmd_valid,
  input  logic                      cmd_ready,
  output logic                      cmd_pause,
  output logic [HOST_W-1:0]         cmd_host,
  output logic [CLASS_W-1:0]        cmd_class,
  output logic                      overrun
);
  typedef enum logic [1:0] {S_IDLE, S_PAUSE, S_UNP, S_WAIT} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cyc, len_q, guard_q;
  logic [SLOT_W-1:0] slot, nsl_q;
  logic [HOST_W-1:0] pos;
  logic [GRP_W-1:0]  grp_rot;
  logic [HIG_W-1:0]  hig_rot;

  logic [HOST_W-1:0] host;
  logic              slot_end, last_slot, guard_done, host_sel, pos_last;

  assign host       = {pos[HOST_W-1:HIG_W] + grp_rot, pos[HIG_W-1:0] + hig_rot};
  assign slot_end   = (cyc == len_q - 1'b1);
  assign last_slot  = (slot == nsl_q - 1'b1);
  assign guard_done = (cyc >= guard_q);
  assign host_sel   = sched_mask[host];
  assign pos_last   = (pos == {HOST_W{1'b1}});

  assign sched_slot = slot;
  assign cmd_pause  = (st == S_PAUSE);
  assign cmd_valid  = cmd_pause || (st == S_UNP && guard_done && host_sel);
  assign cmd_host   = cmd_pause ? '0 : host;
  assign cmd_class  = cmd_pause ? '0 : sched_class[host*CLASS_W +: CLASS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cyc     <= '0;
      len_q   <= '0;
      guard_q <= '0;
      nsl_q   <= '0;
      slot    <= '0;
      pos     <= '0;
      grp_rot <= '0;
      hig_rot <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= 1'b0;
      if (st == S_IDLE) begin
        if (run) begin
          len_q   <= cfg_slot_len;
          guard_q <= cfg_guard_len;
          nsl_q   <= cfg_num_slots;
          st      <= S_PAUSE;
          cyc     <= '0;
          slot    <= '0;
          pos     <= '0;
        end
      end else if (slot_end) begin
        overrun <= (st != S_WAIT);
        cyc     <= '0;
        pos     <= '0;
        st      <= S_PAUSE;
        if (last_slot) begin
          slot    <= '0;
          len_q   <= cfg_slot_len;
          guard_q <= cfg_guard_len;
          nsl_q   <= cfg_num_slots;
          grp_rot <= grp_rot + 1'b1;
          hig_rot <= hig_rot + 1'b1;
          if (!run) st <= S_IDLE;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        cyc <= cyc + 1'b1;
        if (st == S_PAUSE && cmd_ready) st <= S_UNP;
        if (st == S_UNP && guard_done && (!host_sel || cmd_ready)) begin
          if (pos_last) st <= S_WAIT;
          else pos <= pos + 1'b1;
        end
      end
    end
  end

  assert_overrun_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && st != S_IDLE) |-> (cmd_valid && cmd_pause));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !slot_end) |=>
      (cmd_valid && $stable(cmd_host) && $stable(cmd_pause) && $stable(cmd_class)));

  assert_masked_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_pause) |-> sched_mask[cmd_host]);

  assert_single_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_pause && cmd_ready) |=> !(cmd_valid && cmd_pause));

  assert_slot_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (sched_slot < nsl_q));
endmodule

// File: tb/sim_tdma_slot_sequencer.sv
module sim_tdma_slot_sequencer;
  logic clk = 1'b0;
  logic rst_n, run, rdy_en;
  logic [15:0] cfg_slot_len, cfg_guard_len;
  logic [3:0]  cfg_num_slots, sched_slot;
  logic [3:0]  sched_mask;
  logic [11:0] sched_class;
  logic cmd_valid, cmd_ready, cmd_pause, overrun;
  logic [1:0] cmd_host;
  logic [2:0] cmd_class;
  int phase = 0;

  always #10 clk = ~clk;

  tdma_slot_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_slot_len(cfg_slot_len), .cfg_guard_len(cfg_guard_len), .cfg_num_slots(cfg_num_slots),
    .sched_slot(sched_slot), .sched_mask(sched_mask), .sched_class(sched_class),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_pause(cmd_pause),
    .cmd_host(cmd_host), .cmd_class(cmd_class), .overrun(overrun));

  assign cmd_ready = rdy_en | cmd_pause;

  function automatic logic [3:0] mskf(int s);
    case (s)
      0: return 4'b1011;
      1: return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int clsf(int h, int s);
    return (h * 3 + s + 1) % 8;
  endfunction

  function automatic int hostf(int p, int r);
    return (((p / 2) + r) % 2) * 2 + ((p % 2) + r) % 2;
  endfunction

  always_comb begin
    sched_mask = (phase != 0) ? 4'hF : mskf(int'(sched_slot));
    for (int h = 0; h < 4; h++) sched_class[h*3 +: 3] = 3'(clsf(h, int'(sched_slot)));
  end

  int tcnt = 0;
  always @(posedge clk) tcnt <= tcnt + 1;

  int  ev_t[64], ev_h[64], ev_c[64];
  bit  ev_p[64];
  int  nlog = 0, ovr_cnt = 0;
  always @(negedge clk) begin
    if (cmd_valid && cmd_ready && nlog < 64) begin
      ev_t[nlog] = tcnt;
      ev_p[nlog] = cmd_pause;
      ev_h[nlog] = int'(cmd_host);
      ev_c[nlog] = int'(cmd_class);
      nlog = nlog + 1;
    end
    if (overrun) ovr_cnt = ovr_cnt + 1;
  end

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", tcnt, 0);
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int idx, t, lr, gr, b0, ov0, h;
    rst_n = 1'b0; run = 1'b0; rdy_en = 1'b1;
    cfg_slot_len = 16'd20; cfg_guard_len = 16'd5; cfg_num_slots = 4'd3;
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 reset valid", int'(cmd_valid), 0);
    chk(overrun == 1'b0, "R1 reset overrun", int'(overrun), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 idle", int'(cmd_valid), 0);

    run = 1'b1;
    while (nlog < 1) @(negedge clk);
    repeat (5) @(negedge clk);
    cfg_slot_len = 16'd24; cfg_guard_len = 16'd3;
    while (nlog < 31) @(negedge clk);
    run = 1'b0;
    repeat (150) @(negedge clk);
    chk(nlog == 40, "R8 command count after stop", nlog, 40);

    idx = 0; t = ev_t[0];
    for (int r = 0; r < 4; r++) begin
      lr = (r == 0) ? 20 : 24;
      gr = (r == 0) ? 5 : 3;
      for (int s = 0; s < 3; s++) begin
        chk(ev_p[idx] == 1'b1, "R2 pause first", int'(ev_p[idx]), 1);
        chk(ev_t[idx] == t, "R2/R7 pause time", ev_t[idx] - ev_t[0], t - ev_t[0]);
        chk(ev_h[idx] == 0 && ev_c[idx] == 0, "R2 pause fields", ev_h[idx] * 8 + ev_c[idx], 0);
        idx++;
        if (s == 1)
          chk(ev_p[idx] == 1'b1, "R5 empty slot no unpause", int'(ev_p[idx]), 1);
        for (int p = 0; p < 4; p++) begin
          h = hostf(p, r);
          if (mskf(s)[h]) begin
            chk(ev_p[idx] == 1'b0, "R4 unpause kind", int'(ev_p[idx]), 0);
            chk(ev_h[idx] == h, "R6 host order", ev_h[idx], h);
            chk(ev_c[idx] == clsf(h, s), "R4/R10 class", ev_c[idx], clsf(h, s));
            chk(ev_t[idx] == t + gr + p, "R3/R7 unpause time", ev_t[idx] - t, gr + p);
            idx++;
          end
        end
        t = t + lr;
      end
    end
    chk(ovr_cnt == 0, "R9 no overrun with ready", ovr_cnt, 0);

    phase = 1; rdy_en = 1'b0;
    cfg_slot_len = 16'd12; cfg_guard_len = 16'd5; cfg_num_slots = 4'd2;
    b0 = nlog; ov0 = ovr_cnt;
    @(negedge clk);
    run = 1'b1;
    while (nlog < b0 + 3) @(negedge clk);
    run = 1'b0;
    repeat (60) @(negedge clk);
    chk(nlog - b0 == 4, "R9 only pauses under stall", nlog - b0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(ev_p[b0 + k] == 1'b1, "R9 stalled slot pause", int'(ev_p[b0 + k]), 1);
      chk(ev_t[b0 + k] - ev_t[b0] == 12 * k, "R9 pause on time", ev_t[b0 + k] - ev_t[b0], 12 * k);
    end
    chk(ovr_cnt - ov0 == 4, "R9 overrun pulses", ovr_cnt - ov0, 4);
    chk(cmd_valid == 1'b0, "R8 idle after stop", int'(cmd_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule